// File: doc/BRIEF.md
# Rate 2/3 (1,7) Run-Length-Limited Encoder

This block turns a stream of NRZ data bits, taken two at a time, into a (1,7) constrained code in which every 1 is followed by at least one and at most seven 0s. Each data pair becomes a three-bit codeword. The choice of codeword depends on three things: the present pair, the pair that follows it, and whether the previous codeword already consumed the present pair. A plain pair-to-word lookup would let a codeword ending in 1 be followed by one starting in 1. The block prevents this by merging two pairs into a six-bit group whenever that would happen. The second word of such a group is all zeros.

Data pairs arrive on a valid/ready handshake. The block holds one pair so that it can look at the pair after it. A pair's codeword is therefore emitted when the pair after it is accepted. A pair flagged as last is flushed on its own, with an all-zero pair assumed to follow. A synchronous sector-start input discards the held pair and the group state, so each sector is coded from a clean history.

Top module: `rll17_encoder`

## Requirements
- R1: After reset, `cw_valid` is 0 and `in_ready` is 1.
- R2: A pair that does not take part in a group is coded with `in_pair[1]` as the earlier data bit and `cw_word[2]` as the first code bit. The mapping is 00 to 101, 01 to 100, 10 to 001 and 11 to 010.
- R3: A group forms when the held pair's later bit is 0 and the next pair's earlier bit is 0. The held pair is then coded as the R2 word of {held earlier bit, next later bit}.
- R4: The pair consumed by a group is emitted as 000. It never heads a group itself, so two 000 words are never adjacent.
- R5: The first pair of a sector produces no codeword when it is accepted. Every later acceptance emits the held pair's word, with `cw_valid` high in the cycle after the accepting edge.
- R6: A pair accepted with `in_last` set is flushed in the following cycle as if a 00 pair followed. It is emitted as 000 if consumed, and otherwise as its R2 word. `in_ready` is 0 during that flush cycle, and the block is then empty.
- R7: `sector_start` empties the block and clears the group state. It produces no codeword and holds `in_ready` at 0 in its cycle. It overrides both acceptance and flush.
- R8: Within a sector, the emitted bit stream never has two adjacent 1s and never has more than seven 0s in a row, including across codeword boundaries.
- R9: While `in_valid` is 0 and no flush is due, no codeword is emitted and the held pair is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_start | input | 1 | Synchronous history clear at a sector boundary |
| in_valid | input | 1 | Data pair offered |
| in_ready | output | 1 | Data pair will be taken on this edge |
| in_pair | input | 2 | Data pair, bit 1 earlier in time |
| in_last | input | 1 | Offered pair ends the data |
| cw_valid | output | 1 | Codeword present this cycle |
| cw_word | output | 3 | Codeword, bit 2 first on the medium |

## Verification
Two collisions matter here, and the bench provokes both with `sector_start`. In the first, `sector_start` arrives in the very cycle a flush is due, just after a last pair has been taken. The check is that no codeword appears at all, because the sector start wins over the flush. In the second, `sector_start` is raised while a pair is offered. The check is that `in_ready` is low and that the pair leaves no trace in the codewords of the next message. Every message of one to five pairs is also swept. Each one is checked word by word against an arithmetic model, for the run-length limits, and by decoding it back to the data.

// File: rtl/rll17_encoder.sv
module rll17_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sector_start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_pair,
  input  logic       in_last,
  output logic       cw_valid,
  output logic [2:0] cw_word
);
  logic [1:0] cur;
  logic       cur_v, cur_last, sub;

  function automatic logic [2:0] base_word(input logic [1:0] p);
    case (p)
      2'b00:   base_word = 3'b101;
      2'b01:   base_word = 3'b100;
      2'b10:   base_word = 3'b001;
      default: base_word = 3'b010;
    endcase
  endfunction

  logic flush, take, head, emit;
  logic [2:0] word;

  assign flush    = cur_v && cur_last;
  assign in_ready = !flush && !sector_start;
  assign take     = in_valid && in_ready;
  assign head     = !sub && !cur[0] && !in_pair[1];
  assign emit     = !sector_start && cur_v && (flush || take);
  assign word     = sub ? 3'b000 :
                    (take && head) ? base_word({cur[1], in_pair[0]}) : base_word(cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= 2'b00;
      cur_v    <= 1'b0;
      cur_last <= 1'b0;
      sub      <= 1'b0;
      cw_valid <= 1'b0;
      cw_word  <= 3'b000;
    end else begin
      cw_valid <= emit;
      if (emit) cw_word <= word;
      if (sector_start) begin
        cur_v <= 1'b0;
        sub   <= 1'b0;
      end else if (flush) begin
        cur_v <= 1'b0;
        sub   <= 1'b0;
      end else if (take) begin
        cur      <= in_pair;
        cur_last <= in_last;
        cur_v    <= 1'b1;
        sub      <= cur_v && head;
      end
    end
  end
endmodule

module rll17_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sector_start,
  input logic       in_valid,
  input logic       in_ready,
  input logic       cw_valid,
  input logic [2:0] cw_word,
  input logic       cur_v,
  input logic       cur_last
);
  logic last_lsb, prev_zero;

  always_ff @(posedge clk) begin
    if (!rst_n || sector_start) begin
      last_lsb  <= 1'b0;
      prev_zero <= 1'b0;
    end else if (cw_valid) begin
      last_lsb  <= cw_word[0];
      prev_zero <= (cw_word == 3'b000);
    end
  end

  assert_word_no_adjacent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> !(cw_word[2] && cw_word[1]) && !(cw_word[1] && cw_word[0]));
  assert_boundary_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && last_lsb |-> !cw_word[2]);
  assert_single_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && prev_zero |-> cw_word != 3'b000);
  assert_sector_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sector_start |=> !cw_valid);
  assert_sector_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sector_start |-> !in_ready);
  assert_flush_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_v && cur_last && !sector_start |=> cw_valid && !cur_v);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !(cur_v && cur_last) |=> !cw_valid);
endmodule

bind rll17_encoder rll17_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sector_start(sector_start), .in_valid(in_valid),
  .in_ready(in_ready), .cw_valid(cw_valid), .cw_word(cw_word),
  .cur_v(cur_v), .cur_last(cur_last)
);

// File: tb/rll17_encoder_bench.sv
module rll17_encoder_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sector_start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [1:0] in_pair = 2'b00;
  logic in_ready, cw_valid;
  logic [2:0] cw_word;

  rll17_encoder u_rll17_encoder (
    .clk(clk), .rst_n(rst_n), .sector_start(sector_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_pair(in_pair), .in_last(in_last),
    .cw_valid(cw_valid), .cw_word(cw_word)
  );

  int checks = 0, errors = 0, got_n = 0, cycles = 0;
  logic [2:0] got [16];
  logic [2:0] exp_w [16];
  int exp_n;

  always @(negedge clk) begin
    cycles++;
    if (cw_valid) begin
      if (got_n < 16) got[got_n] = cw_word;
      got_n++;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] w_of(input logic [1:0] p);
    return (p == 2'd0) ? 3'b101 : (p == 2'd1) ? 3'b100 : (p == 2'd2) ? 3'b001 : 3'b010;
  endfunction

  task automatic sector_pulse();
    @(negedge clk) sector_start = 1'b1;
    @(negedge clk) sector_start = 1'b0;
    got_n = 0;
  endtask

  task automatic send_pair(input logic [1:0] d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_pair = d; in_last = last;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_msg(input int len, input int code);
    logic [1:0] p [8];
    int i, ones_gap, last_one, nb;
    bit dk_ok, rt_ok;
    logic [1:0] dec [8];
    int dn;
    for (int k = 0; k < len; k++) p[k] = 2'((code >> (2 * (len - 1 - k))) & 3);
    sector_pulse();
    for (int k = 0; k < len; k++) send_pair(p[k], k == len - 1);
    repeat (3) @(negedge clk);
    exp_n = 0; i = 0;
    while (i < len) begin
      if (i + 1 < len && p[i][0] == 1'b0 && p[i+1][1] == 1'b0) begin
        exp_w[exp_n++] = w_of({p[i][1], p[i+1][0]});
        exp_w[exp_n++] = 3'b000;
        i += 2;
      end else begin
        exp_w[exp_n++] = w_of(p[i]);
        i += 1;
      end
    end
    chk(got_n == exp_n, "R5 R6 word count", got_n, exp_n);
    if (got_n == exp_n)
      for (int k = 0; k < exp_n; k++)
        chk(got[k] == exp_w[k], "R2 R3 R4 R6 codeword", int'(got[k]), int'(exp_w[k]));
    dk_ok = 1'b1; last_one = -1; nb = 3 * ((got_n < 16) ? got_n : 16);
    for (int b = 0; b < nb; b++) begin
      if (got[b / 3][2 - (b % 3)]) begin
        ones_gap = b - last_one - 1;
        if (last_one >= 0 && ones_gap < 1) dk_ok = 1'b0;
        if (ones_gap > 7) dk_ok = 1'b0;
        last_one = b;
      end
    end
    if (nb - last_one - 1 > 7) dk_ok = 1'b0;
    chk(dk_ok, "R8 run-length", int'(dk_ok), 1);
    dn = 0;
    for (int k = 0; k < got_n && k < 16 && dn < 8; k++) begin
      logic [1:0] dp;
      dp = (got[k] == 3'b101) ? 2'd0 : (got[k] == 3'b100) ? 2'd1 : (got[k] == 3'b001) ? 2'd2 : 2'd3;
      if (k + 1 < got_n && got[k+1] == 3'b000 && dn < 7) begin
        dec[dn++] = {dp[1], 1'b0};
        dec[dn++] = {1'b0, dp[0]};
        k++;
      end else dec[dn++] = dp;
    end
    rt_ok = (dn == len);
    for (int k = 0; k < len && k < dn; k++) if (dec[k] != p[k]) rt_ok = 1'b0;
    chk(rt_ok, "R2 R3 R4 round-trip", code, code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cw_valid == 1'b0, "R1 cw_valid", int'(cw_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R9 stall then R5 timing and R6 flush
    sector_pulse();
    send_pair(2'd3, 1'b0);
    repeat (5) @(negedge clk);
    chk(got_n == 0, "R9 no word while idle", got_n, 0);
    send_pair(2'd3, 1'b1);
    chk(cw_valid && cw_word == 3'b010, "R5 word after accept", int'(cw_word), 2);
    #1;
    chk(in_ready == 1'b0, "R6 in_ready low in flush", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk(got_n == 2 && got[1] == 3'b010, "R6 flushed word", got_n, 2);

    // R7 held pair discarded by sector start
    sector_pulse();
    send_pair(2'd0, 1'b0);
    sector_pulse();
    send_pair(2'd0, 1'b0);
    send_pair(2'd0, 1'b1);
    repeat (3) @(negedge clk);
    chk(got_n == 2, "R7 held pair dropped", got_n, 2);

    // R7 collision with an offered pair
    sector_pulse();
    @(negedge clk);
    in_valid = 1'b1; in_pair = 2'd2; in_last = 1'b0; sector_start = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R7 in_ready low", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0; sector_start = 1'b0;
    got_n = 0;
    send_pair(2'd1, 1'b1);
    repeat (3) @(negedge clk);
    chk(got_n == 1 && got[0] == 3'b100, "R7 offered pair ignored", got_n, 1);

    // R7 collision with a flush
    sector_pulse();
    send_pair(2'd3, 1'b1);
    sector_start = 1'b1;
    @(negedge clk);
    sector_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_n == 0, "R7 R6 sector start beats flush", got_n, 0);

    for (int len = 1; len <= 5; len++)
      for (int code = 0; code < (1 << (2 * len)); code++)
        run_msg(len, code);

    finish_run();
  end
endmodule